// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Engine

This block is a bus-master DMA controller. Software places a chain of three-word descriptors in memory, loads the address of the first descriptor into one of two list-pointer registers, and writes a start command. The engine then works through the chain on its own. For each descriptor it fetches the three words, checks the byte count, and copies that many bytes one 32-bit word at a time from the source address to the destination address. It stops after the descriptor that carries the end-of-list flag.

There are two directions, read and write. Each has its own list pointer, its own enable bit, its own busy bit and its own error bit. A bad byte count is reported on a separate linked-list error bit. A single interrupt output pulses when a chain finishes or when a chain is abandoned because of an error. Software can stop a running chain, and it can cancel it. Cancel also clears the error bits.

All memory traffic goes through one simple master port. The port holds a request until the memory acknowledges it. Read data and the error flag are taken in the same cycle as the acknowledge.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the status word reads 0, `irq_o` is low and no memory request is issued.
- R2: A descriptor is three words at byte offsets +0 (source), +4 (destination) and +8 (control) from its base address. The next descriptor in a chain starts 12 bytes after the current one. Register word offsets: 0 control, 1 status, 2 read list pointer, 3 write list pointer, 4 enable. The pointer and enable registers read back what was written.
- R3: For a valid descriptor, the engine copies count/4 words from the source to the destination in ascending address order. The count is in bits [15:0] of the control word.
- R4: Bit 31 of the control word marks the last descriptor. When a last descriptor completes, busy clears and `irq_o` pulses for exactly one cycle. A descriptor without the flag is followed by the next one in the chain, and no interrupt is raised.
- R5: A count of zero, or a count that is not a multiple of 256, sets status bit 4 (linked-list error). No data is moved for that descriptor, the chain is abandoned and `irq_o` pulses.
- R6: Writing 1 to the control register starts the read chain from the read pointer. Writing 2 starts the write chain from the write pointer. Status bit 0 is read-busy and bit 1 is write-busy. A start command has no effect while the engine is busy.
- R7: Enable bit 0 allows read chains and enable bit 1 allows write chains. A start command for a disabled direction is ignored: nothing is moved and no busy bit is set.
- R8: Writing 4 to the control register stops a running chain. Busy clears, no interrupt is raised and no further memory access is made.
- R9: A memory error response sets status bit 2 during a read chain and status bit 3 during a write chain. The chain is abandoned and `irq_o` pulses.
- R10: Error bits stay set across later chains. Writing 0 to the control register clears them and cancels any running chain without an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted this cycle |
| mem_err_i | input | 1 | Error response, valid with `mem_ack_i` |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ack_i` |
| irq_o | output | 1 | One-cycle completion or error interrupt |

## Verification
The assertions assume three things about the inputs:
- Software writes only word-aligned list pointers and places descriptors with word-aligned source and destination addresses.
- Control writes arrive no faster than one per cycle.
- The memory gives an error only together with an acknowledge.

The bench keeps to these assumptions. All descriptors and buffers sit on word boundaries inside a 4 KB model memory, registers are written one at a time, and the memory acknowledges every request in the cycle it is raised. The bench injects an error only by matching one chosen address while a request is active.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_F0, W_F1, W_F2, W_CHK, W_RD, W_WR
  } walk_st_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_RPTR = 3'd2;
  localparam logic [2:0] REG_WPTR = 3'd3;
  localparam logic [2:0] REG_EN   = 3'd4;

  localparam int unsigned CMD_CANCEL = 0;
  localparam int unsigned CMD_RD     = 1;
  localparam int unsigned CMD_WR     = 2;
  localparam int unsigned CMD_STOP   = 4;

  localparam int unsigned N_DIR = 2;  // 0 = read, 1 = write
endpackage

// File: rtl/sg_dma_cnt_chk.sv
module sg_dma_cnt_chk #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GRAN_LOG2 = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_ok_o
);
  logic nonzero, aligned;
  assign nonzero  = |cnt_i;
  assign aligned  = ~|cnt_i[GRAN_LOG2-1:0];
  assign cnt_ok_o = nonzero & aligned;
endmodule

// File: rtl/sg_dma_walker.sv
module sg_dma_walker
  import sg_dma_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GRAN_LOG2 = 8,
  parameter int unsigned LAST_BIT  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_dir_i,
  input  logic [ADDR_W-1:0] list_ptr_i,
  input  logic              halt_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              dir_o,
  output logic              done_o,
  output logic              list_err_o,
  output logic              bus_err_o
);
  localparam int unsigned BYTES_W = DATA_W / 8;
  localparam int unsigned STRIDE  = 3 * BYTES_W;
  localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(BYTES_W);
  localparam logic [CNT_W-1:0]  C_STEP = CNT_W'(BYTES_W);

  walk_st_e          state_q;
  logic [ADDR_W-1:0] desc_q, src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q, remain_q;
  logic              last_q, dir_q;
  logic [DATA_W-1:0] data_q;
  logic              cnt_ok, fire, ok, last_word;

  sg_dma_cnt_chk #(.CNT_W(CNT_W), .GRAN_LOG2(GRAN_LOG2)) u_cnt_chk (
    .cnt_i   (cnt_q),
    .cnt_ok_o(cnt_ok)
  );

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    unique case (state_q)
      W_F0: begin mem_req_o = 1'b1; mem_addr_o = desc_q; end
      W_F1: begin mem_req_o = 1'b1; mem_addr_o = desc_q + A_STEP; end
      W_F2: begin mem_req_o = 1'b1; mem_addr_o = desc_q + 2 * A_STEP; end
      W_RD: begin mem_req_o = 1'b1; mem_addr_o = src_q; end
      W_WR: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = dst_q; end
      default: ;
    endcase
  end
  assign mem_wdata_o = data_q;

  assign fire       = mem_req_o & mem_ack_i;
  assign ok         = fire & ~mem_err_i;
  assign last_word  = (remain_q == C_STEP);
  assign busy_o     = (state_q != W_IDLE);
  assign dir_o      = dir_q;
  assign bus_err_o  = fire & mem_err_i & ~halt_i;
  assign list_err_o = (state_q == W_CHK) & ~cnt_ok & ~halt_i;
  assign done_o     = (state_q == W_WR) & ok & last_word & last_q & ~halt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= W_IDLE;
      desc_q   <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      remain_q <= '0;
      last_q   <= 1'b0;
      dir_q    <= 1'b0;
      data_q   <= '0;
    end else if (halt_i) begin
      state_q <= W_IDLE;
    end else begin
      unique case (state_q)
        W_IDLE: if (start_i) begin
          desc_q  <= list_ptr_i;
          dir_q   <= start_dir_i;
          state_q <= W_F0;
        end
        W_F0: if (fire) begin
          src_q   <= mem_rdata_i;
          state_q <= mem_err_i ? W_IDLE : W_F1;
        end
        W_F1: if (fire) begin
          dst_q   <= mem_rdata_i;
          state_q <= mem_err_i ? W_IDLE : W_F2;
        end
        W_F2: if (fire) begin
          cnt_q   <= mem_rdata_i[CNT_W-1:0];
          last_q  <= mem_rdata_i[LAST_BIT];
          state_q <= mem_err_i ? W_IDLE : W_CHK;
        end
        W_CHK: begin
          remain_q <= cnt_q;
          state_q  <= cnt_ok ? W_RD : W_IDLE;
        end
        W_RD: if (fire) begin
          data_q  <= mem_rdata_i;
          state_q <= mem_err_i ? W_IDLE : W_WR;
        end
        W_WR: if (fire) begin
          if (mem_err_i) begin
            state_q <= W_IDLE;
          end else begin
            src_q    <= src_q + A_STEP;
            dst_q    <= dst_q + A_STEP;
            remain_q <= remain_q - C_STEP;
            if (!last_word)  state_q <= W_RD;
            else if (last_q) state_q <= W_IDLE;
            else begin
              desc_q  <= desc_q + ADDR_W'(STRIDE);
              state_q <= W_F0;
            end
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  // R2: descriptor and data accesses stay word aligned
  a_r2_fetch_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R5: data phase only entered after a count that passed the check
  a_r5_count_checked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == W_RD && $past(state_q) == W_CHK) |-> cnt_ok);

  // R6: accepted start makes the engine busy in the requested direction
  a_r6_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == W_IDLE && start_i && !halt_i) |=> (busy_o && dir_o == $past(start_dir_i)));

  // R8: no access in the cycle after a stop or cancel
  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(halt_i) |-> !mem_req_o);
endmodule

// File: rtl/sg_dma_regs.sv
module sg_dma_regs
  import sg_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RA_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              busy_i,
  input  logic              dir_i,
  input  logic              done_i,
  input  logic              list_err_i,
  input  logic              bus_err_i,
  output logic              start_o,
  output logic              start_dir_o,
  output logic [ADDR_W-1:0] list_ptr_o,
  output logic              halt_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] ptr_q [N_DIR];
  logic [N_DIR-1:0]  en_q;
  logic [N_DIR-1:0]  bus_err_q;
  logic              list_err_q, irq_q;
  logic              ctrl_wr, cmd_cancel, cmd_rd, cmd_wr, cmd_stop;
  logic [4:0]        status;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[d]     <= '0;
        en_q[d]      <= 1'b0;
        bus_err_q[d] <= 1'b0;
      end else begin
        if (reg_we_i && reg_addr_i == RA_W'(REG_RPTR + d)) ptr_q[d] <= reg_wdata_i[ADDR_W-1:0];
        if (reg_we_i && reg_addr_i == RA_W'(REG_EN))       en_q[d]  <= reg_wdata_i[d];
        if (ctrl_wr && cmd_cancel)                         bus_err_q[d] <= 1'b0;
        else if (bus_err_i && dir_i == 1'(d))              bus_err_q[d] <= 1'b1;
      end
    end
  end

  assign ctrl_wr    = reg_we_i && reg_addr_i == RA_W'(REG_CTRL);
  assign cmd_cancel = reg_wdata_i == DATA_W'(CMD_CANCEL);
  assign cmd_rd     = reg_wdata_i == DATA_W'(CMD_RD);
  assign cmd_wr     = reg_wdata_i == DATA_W'(CMD_WR);
  assign cmd_stop   = reg_wdata_i == DATA_W'(CMD_STOP);

  assign start_o     = ctrl_wr && !busy_i && ((cmd_rd && en_q[0]) || (cmd_wr && en_q[1]));
  assign start_dir_o = cmd_wr;
  assign list_ptr_o  = cmd_wr ? ptr_q[1] : ptr_q[0];
  assign halt_o      = ctrl_wr && (cmd_cancel || cmd_stop);
  assign irq_o       = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      list_err_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= done_i | list_err_i | bus_err_i;
      if (ctrl_wr && cmd_cancel) list_err_q <= 1'b0;
      else if (list_err_i)       list_err_q <= 1'b1;
    end
  end

  assign status = {list_err_q, bus_err_q[1], bus_err_q[0], busy_i & dir_i, busy_i & ~dir_i};

  always_comb begin
    unique case (reg_addr_i)
      RA_W'(REG_STAT): reg_rdata_o = DATA_W'(status);
      RA_W'(REG_RPTR): reg_rdata_o = DATA_W'(ptr_q[0]);
      RA_W'(REG_WPTR): reg_rdata_o = DATA_W'(ptr_q[1]);
      RA_W'(REG_EN):   reg_rdata_o = DATA_W'(en_q);
      default:         reg_rdata_o = '0;
    endcase
  end

  // R4: interrupt only while idle, and only one cycle wide
  a_r4_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_i);
  a_r4_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R10: error bits fall only after a cancel
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past({list_err_q, bus_err_q}) & ~{list_err_q, bus_err_q})) |-> $past(ctrl_wr && cmd_cancel));
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GRAN_LOG2 = 8,
  parameter int unsigned LAST_BIT  = 31,
  parameter int unsigned RA_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              irq_o
);
  logic              start, start_dir, halt, busy, dir, done, list_err, bus_err;
  logic [ADDR_W-1:0] list_ptr;

  sg_dma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RA_W(RA_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .dir_i(dir), .done_i(done), .list_err_i(list_err), .bus_err_i(bus_err),
    .start_o(start), .start_dir_o(start_dir), .list_ptr_o(list_ptr), .halt_o(halt), .irq_o
  );

  sg_dma_walker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .GRAN_LOG2(GRAN_LOG2), .LAST_BIT(LAST_BIT)
  ) u_walker (
    .clk_i, .rst_ni, .start_i(start), .start_dir_i(start_dir), .list_ptr_i(list_ptr), .halt_i(halt),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_err_i, .mem_rdata_i,
    .busy_o(busy), .dir_o(dir), .done_o(done), .list_err_o(list_err), .bus_err_o(bus_err)
  );
endmodule

// File: tb/sg_dma_engine_test.sv
`timescale 1ns/1ps
module sg_dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_waddr = '0;
  logic [31:0] tb_wdata = '0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  int n_chk = 0, n_bad = 0, irq_cnt = 0;

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam logic [31:0] LAST = 32'h8000_0000;

  always #10 clk = ~clk;

  sg_dma_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .mem_rdata_i(mem_rdata), .irq_o(irq)
  );

  assign mem_ack   = mem_req;
  assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (tb_we) mem[tb_waddr] <= tb_wdata;
    else if (mem_req && mem_we && !mem_err) mem[mem_addr[11:2]] <= mem_wdata;
  end

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = a[11:2]; tb_wdata = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic fill(input logic [31:0] base, input int n, input bit pattern);
    for (int i = 0; i < n; i++) poke(base + 4 * i, pattern ? (32'hA500_0000 | (base + 4 * i)) : SENT);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c);
    poke(a, s); poke(a + 4, d); poke(a + 8, c);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if (s[1:0] == 2'b00) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  // count words in dst that do not hold the source pattern
  function automatic int copy_miss(input logic [31:0] src, input logic [31:0] dst, input int n);
    int m = 0;
    for (int i = 0; i < n; i++) if (mem[(dst >> 2) + i] !== mem[(src >> 2) + i]) m++;
    return m;
  endfunction

  task automatic t_reset();
    logic [31:0] s;
    rd(3'd1, s);
    chk("R1 status after reset", s, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 no request after reset", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd2, 32'h0000_1234); wr(3'd3, 32'h0000_5678); wr(3'd4, 32'h3);
    rd(3'd2, v); chk("R2 read pointer readback", v, 32'h1234);
    rd(3'd3, v); chk("R2 write pointer readback", v, 32'h5678);
    rd(3'd4, v); chk("R2 enable readback", v, 32'h3);
  endtask

  task automatic t_single_write();
    logic [31:0] s;
    int i0;
    fill(32'h800, 64, 0);
    put_desc(32'h000, 32'h400, 32'h800, LAST | 32'h100);
    wr(3'd3, 32'h000);
    i0 = irq_cnt;
    wr(3'd0, 32'd2);
    rd(3'd1, s);
    chk("R6 write busy while running", s, 32'h2);
    wait_idle();
    rd(3'd1, s);
    chk("R4 status idle after last descriptor", s, 32'h0);
    chk("R3 single descriptor copy misses", copy_miss(32'h400, 32'h800, 64), 0);
    chk("R4 one irq for last descriptor", irq_cnt - i0, 1);
  endtask

  task automatic t_chain_read();
    logic [31:0] s;
    int i0;
    fill(32'hC00, 128, 0);
    put_desc(32'h040, 32'h400, 32'hC00, 32'h100);
    put_desc(32'h04C, 32'h500, 32'hD00, LAST | 32'h100);
    wr(3'd2, 32'h040);
    i0 = irq_cnt;
    wr(3'd0, 32'd1);
    rd(3'd1, s);
    chk("R6 read busy while running", s, 32'h1);
    wait_idle();
    chk("R2 first descriptor copy misses", copy_miss(32'h400, 32'hC00, 64), 0);
    chk("R2 second descriptor at stride 12 copy misses", copy_miss(32'h500, 32'hD00, 64), 0);
    chk("R4 no irq for non-last descriptor", irq_cnt - i0, 1);
  endtask

  task automatic t_list_err();
    logic [31:0] s;
    int i0;
    fill(32'h800, 4, 0);
    put_desc(32'h080, 32'h400, 32'h800, LAST | 32'h180);
    wr(3'd3, 32'h080);
    i0 = irq_cnt;
    wr(3'd0, 32'd2);
    wait_idle();
    rd(3'd1, s);
    chk("R5 list error for count 0x180", s, 32'h10);
    chk("R5 nothing moved on bad count", mem[32'h800 >> 2], SENT);
    chk("R5 irq on list error", irq_cnt - i0, 1);
    // R10: error survives a good run
    wr(3'd3, 32'h000);
    fill(32'h800, 64, 0);
    wr(3'd0, 32'd2);
    wait_idle();
    rd(3'd1, s);
    chk("R10 list error sticky across good run", s, 32'h10);
    chk("R10 good run still copies", copy_miss(32'h400, 32'h800, 64), 0);
    wr(3'd0, 32'd0);
    rd(3'd1, s);
    chk("R10 cancel clears errors", s, 32'h0);
    // zero count
    put_desc(32'h080, 32'h400, 32'h800, LAST);
    wr(3'd3, 32'h080);
    wr(3'd0, 32'd2);
    wait_idle();
    rd(3'd1, s);
    chk("R5 list error for zero count", s, 32'h10);
    wr(3'd0, 32'd0);
  endtask

  task automatic t_enable();
    logic [31:0] s;
    int i0;
    fill(32'h800, 2, 0);
    wr(3'd3, 32'h000);
    wr(3'd4, 32'h1);
    i0 = irq_cnt;
    wr(3'd0, 32'd2);
    repeat (10) @(negedge clk);
    rd(3'd1, s);
    chk("R7 disabled write start stays idle", s, 32'h0);
    chk("R7 disabled write moves nothing", mem[32'h800 >> 2], SENT);
    wr(3'd4, 32'h0);
    wr(3'd2, 32'h000);
    wr(3'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd(3'd1, s);
    chk("R7 disabled read start stays idle", s, 32'h0);
    chk("R7 disabled read moves nothing", mem[32'h800 >> 2], SENT);
    chk("R7 no irq when disabled", irq_cnt - i0, 0);
    wr(3'd4, 32'h3);
  endtask

  task automatic t_stop();
    logic [31:0] s;
    int i0;
    fill(32'h800, 128, 0);
    put_desc(32'h090, 32'h400, 32'h800, LAST | 32'h200);
    wr(3'd3, 32'h090);
    i0 = irq_cnt;
    wr(3'd0, 32'd2);
    wr(3'd0, 32'd1); // R6: start while busy ignored
    rd(3'd1, s);
    chk("R6 start while busy ignored", s, 32'h2);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'd4);
    rd(3'd1, s);
    chk("R8 stop clears busy", s, 32'h0);
    repeat (20) @(negedge clk);
    chk("R8 copy began before stop", mem[32'h800 >> 2], mem[32'h400 >> 2]);
    chk("R8 no write after stop", mem[(32'h800 >> 2) + 127], SENT);
    chk("R8 no irq on stop", irq_cnt - i0, 0);
  endtask

  task automatic t_bus_err();
    logic [31:0] s;
    int i0;
    fill(32'h800, 4, 0);
    put_desc(32'h0A0, 32'h400, 32'h800, LAST | 32'h100);
    wr(3'd2, 32'h0A0); wr(3'd3, 32'h0A0);
    err_addr = 32'h408; err_en = 1'b1;
    i0 = irq_cnt;
    wr(3'd0, 32'd1);
    wait_idle();
    rd(3'd1, s);
    chk("R9 read chain error bit", s, 32'h4);
    chk("R9 word before error copied", mem[(32'h800 >> 2) + 1], mem[(32'h400 >> 2) + 1]);
    chk("R9 failed word not written", mem[(32'h800 >> 2) + 2], SENT);
    chk("R9 abort after error", mem[(32'h800 >> 2) + 3], SENT);
    chk("R9 irq on bus error", irq_cnt - i0, 1);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'd2);
    wait_idle();
    rd(3'd1, s);
    chk("R9 write chain error bit", s, 32'h8);
    err_en = 1'b0;
    wr(3'd0, 32'd0);
    rd(3'd1, s);
    chk("R10 cancel clears write error", s, 32'h0);
  endtask

  initial begin
    fill(32'h400, 128, 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_single_write();
    t_chain_read();
    t_list_err();
    t_enable();
    t_stop();
    t_bus_err();
    summary();
    $finish;
  end
endmodule